// File: doc/BRIEF.md
# Non-volatile Memory Read Line Buffer

The block sits between a bus slave port and the slow word-wide read port of a non-volatile array. It keeps a small set of line buffers, each holding one aligned 32-byte line, together with that line's address and a valid flag. Every accepted read is compared against all valid line addresses before the array is touched. On a hit the addressed bytes are returned from the buffer. On a miss the least-recently-used buffer is invalidated and refilled with the whole line, one 32-bit word per array handshake. Once the line address is recorded and the buffer is marked valid, the read completes from the buffer.

A read is either single or burst. A single read returns one byte, halfword or word, moved to the low lanes of the data bus. A burst read returns full words, starting at the word that holds the request address and stepping 4 bytes per beat. It stops at the last word of the line and never wraps or crosses into the next line. A global invalidate input drops every buffered line, for use after the array contents change.

Top module: `nvm_burst_buf`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `arr_req` are 0, and every buffer is invalid, so the first read of any line goes to the array.
- R2: A read whose line address matches a valid buffer makes no array request, and its first response beat is on `rsp_valid` in the cycle after the request is accepted.
- R3: A read that misses makes exactly eight array requests. Word addresses are `{line, k}` for k = 0..7 in ascending order, and each address is held steady while `arr_ready` is low.
- R4: The first response beat of a missed read appears in the cycle after the eighth array handshake, with data taken from the freshly filled line.
- R5: With two buffers, a miss replaces the buffer that was not used most recently, where a hit or a fill counts as a use. After reset, buffer 0 is replaced first.
- R6: Single reads select lanes little-endian, with the upper bits zero. `req_size` 0 returns the byte at address bits [1:0] in `rsp_data[7:0]` (byte n is word bits 8n+7:8n). `req_size` 1 returns the halfword chosen by address bit 1 in `rsp_data[15:0]`, ignoring address bit 0. `req_size` 2 returns the whole word.
- R7: A burst read (`req_burst` = 1) returns full words on consecutive cycles, whatever `req_size` is. It starts at word index `req_addr[4:2]` and the word address advances by one per beat.
- R8: `rsp_last` marks the final beat. A burst has 8 − `req_addr[4:2]` beats and ends on word 7 of the line, and a single read has exactly one beat.
- R9: A one-cycle pulse on `inv_all` clears every valid flag, so the next read of any previously buffered line misses and refetches.
- R10: `req_ready` is 1 only while no read is in progress, and a request is taken when `req_valid` and `req_ready` are both 1. The cycle after the `rsp_last` beat, `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Clear all buffer valid flags |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word (single reads) |
| req_burst | input | 1 | Burst read to end of line |
| req_ready | output | 1 | Block idle, request will be taken |
| rsp_valid | output | 1 | Response beat present |
| rsp_data | output | DATA_W | Response data, lane-aligned to bit 0 |
| rsp_last | output | 1 | Final beat of the read |
| arr_req | output | 1 | Array word request |
| arr_addr | output | ADDR_W-2 | Array word address |
| arr_ready | input | 1 | Array word returned this cycle |
| arr_data | input | DATA_W | Array read data |

## Verification
A hit's first beat is due one cycle after the accepting edge, and a miss's first beat is due one cycle after the eighth array handshake. Burst beats follow on back-to-back cycles, and `req_ready` returns one cycle after the last beat. The bench samples on falling edges. It counts array handshakes and records the cycle of the last one, so each latency is checked at exactly the cycle it is due, not by waiting for it. The array model returns a variable number of wait cycles, which tests the address-hold rule. A bench-side model of the replacement order and the fill data predicts whether each read hits and which bytes come back.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } nbb_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_XFER = 2'd2
   } nbb_state_e;

endpackage

// File: rtl/nbb_match.sv
// Parallel line-address compare across all buffers.
module nbb_match #(
   parameter int NUM_BUF = 2,
   parameter int TAG_W   = 11,
   parameter int IDX_W   = 1
) (
   input  logic [NUM_BUF-1:0][TAG_W-1:0] tags,
   input  logic [NUM_BUF-1:0]            valid,
   input  logic [TAG_W-1:0]              look_tag,
   output logic                          hit,
   output logic [IDX_W-1:0]              hit_idx
);

   logic [NUM_BUF-1:0] eq;

   for (genvar g = 0; g < NUM_BUF; g++) begin : g_cmp
      assign eq[g] = valid[g] && (tags[g] == look_tag);
   end

   always_comb begin
      hit     = |eq;
      hit_idx = '0;
      for (int i = 0; i < NUM_BUF; i++) begin
         if (eq[i]) hit_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/nbb_victim.sv
// Replacement choice: true LRU for two buffers, rotating pointer otherwise.
module nbb_victim #(
   parameter int NUM_BUF = 2,
   parameter int IDX_W   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch,
   input  logic [IDX_W-1:0] touch_idx,
   output logic [IDX_W-1:0] victim
);

   if (NUM_BUF == 2) begin : g_lru
      logic mru_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     mru_q <= 1'b1;
         else if (touch) mru_q <= touch_idx[0];
      end
      assign victim = ~mru_q;
   end else begin : g_rot
      logic [IDX_W-1:0] ptr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ptr_q <= '0;
         else if (touch && (touch_idx == ptr_q))
            ptr_q <= (ptr_q == IDX_W'(NUM_BUF-1)) ? '0 : ptr_q + 1'b1;
      end
      assign victim = ptr_q;
   end

endmodule

// File: rtl/nbb_lane.sv
// Moves the addressed byte or halfword down to bit 0.
module nbb_lane #(
   parameter int DATA_W = 32,
   parameter int BOFF_W = 2
) (
   input  logic [DATA_W-1:0] word,
   input  logic [BOFF_W-1:0] lane,
   input  logic [1:0]        size,
   output logic [DATA_W-1:0] data
);

   import nbb_pkg::*;

   always_comb begin
      unique case (size)
         SZ_BYTE: data = DATA_W'(word[{lane, 3'b000} +: 8]);
         SZ_HALF: data = DATA_W'(word[{lane[BOFF_W-1:1], 4'b0000} +: 16]);
         default: data = word;
      endcase
   end

endmodule

// File: rtl/nvm_burst_buf.sv
module nvm_burst_buf #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int NUM_BUF    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inv_all,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_burst,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_last,
   output logic              arr_req,
   output logic [ADDR_W-3:0] arr_addr,
   input  logic              arr_ready,
   input  logic [DATA_W-1:0] arr_data
);

   import nbb_pkg::*;

   localparam int BYTES_W = DATA_W / 8;
   localparam int BOFF_W  = $clog2(BYTES_W);
   localparam int WORDS   = LINE_BYTES / BYTES_W;
   localparam int WIDX_W  = $clog2(WORDS);
   localparam int OFF_W   = $clog2(LINE_BYTES);
   localparam int TAG_W   = ADDR_W - OFF_W;
   localparam int IDX_W   = $clog2(NUM_BUF);
   localparam int WADDR_W = ADDR_W - BOFF_W;

   if (DATA_W != 32) begin : g_bad_dw
      $error("nvm_burst_buf: DATA_W must be 32");
   end
   if (NUM_BUF < 2) begin : g_bad_nb
      $error("nvm_burst_buf: NUM_BUF must be at least 2");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || WORDS < 2) begin : g_bad_lb
      $error("nvm_burst_buf: LINE_BYTES must be a power of two of at least two words");
   end
   if (TAG_W < 1) begin : g_bad_aw
      $error("nvm_burst_buf: ADDR_W too small for the line size");
   end

   nbb_state_e           st;
   logic [TAG_W-1:0]     cur_tag;
   logic [WIDX_W-1:0]    cur_widx;
   logic [WIDX_W-1:0]    fill_cnt;
   logic [BOFF_W-1:0]    cur_lane;
   logic [1:0]           cur_size;
   logic                 cur_burst;
   logic [IDX_W-1:0]     cur_buf;

   logic [NUM_BUF-1:0][TAG_W-1:0] tag_q;
   logic [NUM_BUF-1:0]            valid_q;
   logic [DATA_W-1:0]             line_mem [NUM_BUF][WORDS];

   logic [TAG_W-1:0]  req_tag;
   logic              hit;
   logic [IDX_W-1:0]  hit_idx;
   logic [IDX_W-1:0]  victim;
   logic              accept;
   logic              fill_beat;
   logic              fill_last;
   logic              xfer_last;
   logic              touch;
   logic [IDX_W-1:0]  touch_idx;
   logic [DATA_W-1:0] rd_word;
   logic [1:0]        eff_size;

   assign req_tag   = req_addr[ADDR_W-1:OFF_W];
   assign accept    = req_valid && (st == ST_IDLE);
   assign fill_beat = (st == ST_FILL) && arr_ready;
   assign fill_last = fill_beat && (fill_cnt == WIDX_W'(WORDS - 1));
   assign xfer_last = (st == ST_XFER) && (!cur_burst || (cur_widx == WIDX_W'(WORDS - 1)));
   assign touch     = (accept && hit) || fill_last;
   assign touch_idx = fill_last ? cur_buf : hit_idx;

   nbb_match #(
      .NUM_BUF (NUM_BUF),
      .TAG_W   (TAG_W),
      .IDX_W   (IDX_W)
   ) u_match (
      .tags     (tag_q),
      .valid    (valid_q),
      .look_tag (req_tag),
      .hit      (hit),
      .hit_idx  (hit_idx)
   );

   nbb_victim #(
      .NUM_BUF (NUM_BUF),
      .IDX_W   (IDX_W)
   ) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch     (touch),
      .touch_idx (touch_idx),
      .victim    (victim)
   );

   // Request and beat sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cur_tag   <= '0;
         cur_widx  <= '0;
         cur_lane  <= '0;
         cur_size  <= '0;
         cur_burst <= 1'b0;
         cur_buf   <= '0;
         fill_cnt  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  cur_tag   <= req_tag;
                  cur_widx  <= req_addr[OFF_W-1:BOFF_W];
                  cur_lane  <= req_addr[BOFF_W-1:0];
                  cur_size  <= req_size;
                  cur_burst <= req_burst;
                  fill_cnt  <= '0;
                  if (hit) begin
                     cur_buf <= hit_idx;
                     st      <= ST_XFER;
                  end else begin
                     cur_buf <= victim;
                     st      <= ST_FILL;
                  end
               end
            end
            ST_FILL: begin
               if (arr_ready) begin
                  fill_cnt <= fill_cnt + 1'b1;
                  if (fill_last) st <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (xfer_last) st <= ST_IDLE;
               else           cur_widx <= cur_widx + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // Valid flags and line addresses: invalidate on miss, set on fill end,
   // global clear wins over both.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         tag_q   <= '0;
      end else begin
         if (accept && !hit) valid_q[victim] <= 1'b0;
         if (fill_last) begin
            valid_q[cur_buf] <= 1'b1;
            tag_q[cur_buf]   <= cur_tag;
         end
         if (inv_all) valid_q <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_beat) line_mem[cur_buf][fill_cnt] <= arr_data;
   end

   assign rd_word  = line_mem[cur_buf][cur_widx];
   assign eff_size = cur_burst ? SZ_WORD : cur_size;

   nbb_lane #(
      .DATA_W (DATA_W),
      .BOFF_W (BOFF_W)
   ) u_lane (
      .word (rd_word),
      .lane (cur_lane),
      .size (eff_size),
      .data (rsp_data)
   );

   assign req_ready = (st == ST_IDLE);
   assign rsp_valid = (st == ST_XFER);
   assign rsp_last  = xfer_last;
   assign arr_req   = (st == ST_FILL);
   assign arr_addr  = WADDR_W'({cur_tag, fill_cnt});

endmodule

// File: rtl/nbb_chk.sv
module nbb_chk #(
   parameter int WADDR_W = 14,
   parameter int WIDX_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               rsp_valid,
   input logic               rsp_last,
   input logic               arr_req,
   input logic               arr_ready,
   input logic [WADDR_W-1:0] arr_addr
);

   a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!rsp_valid && !arr_req));

   a_r3_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_req && !arr_ready) |=> (arr_req && $stable(arr_addr)));

   a_r3_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_req && arr_ready && (arr_addr[WIDX_W-1:0] != '1))
      |=> (arr_req && (arr_addr == $past(arr_addr) + WADDR_W'(1))));

   a_r3_fill_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arr_req) |-> (arr_addr[WIDX_W-1:0] == '0));

   a_r4_rsp_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_req && arr_ready && (arr_addr[WIDX_W-1:0] == '1)) |=> (rsp_valid && !arr_req));

   a_r7_burst_contig: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_last) |=> rsp_valid);

   a_r10_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_last) |=> req_ready);

endmodule

bind nvm_burst_buf nbb_chk #(
   .WADDR_W (WADDR_W),
   .WIDX_W  (WIDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_last  (rsp_last),
   .arr_req   (arr_req),
   .arr_ready (arr_ready),
   .arr_addr  (arr_addr)
);

// File: tb/test_nvm_burst_buf.sv
`timescale 1ns/1ps
module test_nvm_burst_buf;

   localparam int AW = 12;
   localparam int DW = 32;

   logic          clk;
   logic          rst_n;
   logic          inv_all;
   logic          req_valid;
   logic [AW-1:0] req_addr;
   logic [1:0]    req_size;
   logic          req_burst;
   logic          req_ready;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          rsp_last;
   logic          arr_req;
   logic [AW-3:0] arr_addr;
   logic          arr_ready;
   logic [DW-1:0] arr_data;

   nvm_burst_buf #(.ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(32), .NUM_BUF(2)) i_nvm_burst_buf (
      .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
      .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size), .req_burst(req_burst),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
      .arr_req(arr_req), .arr_addr(arr_addr), .arr_ready(arr_ready), .arr_data(arr_data)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int hs_cnt = 0;
   int last_hs_cyc = 0;
   int wait_n = 0;
   int gen = 0;
   int exp_fidx = 0;
   logic [6:0] exp_line = '0;

   logic [6:0] m_tag [2];
   bit         m_val [2];
   int         m_gen [2];
   int         m_mru;

   always @(posedge clk) cyc++;

   function automatic logic [31:0] mdl(input logic [9:0] wa, input int g);
      return (32'(wa) * 32'h9E3779B1) ^ (32'(g) * 32'h01000193) ^ 32'h5A5A0F0F;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Array model: variable wait states, address order checked per word (R3)
   always @(negedge clk) begin
      if (!rst_n) begin
         arr_ready = 1'b0;
         wait_n = 0;
      end else if (arr_ready) begin
         arr_ready = 1'b0;
      end else if (arr_req) begin
         if (wait_n >= (hs_cnt % 3)) begin
            check(arr_addr == {exp_line, 3'(exp_fidx)}, "R3 fill word address",
                  32'(arr_addr), 32'({exp_line, 3'(exp_fidx)}));
            exp_fidx++;
            arr_data    = mdl(arr_addr, gen);
            arr_ready   = 1'b1;
            hs_cnt++;
            last_hs_cyc = cyc;
            wait_n      = 0;
         end else begin
            wait_n++;
         end
      end
   end

   task automatic do_read(input logic [AW-1:0] a, input logic [1:0] sz, input bit bu);
      logic [6:0]  t;
      int          hit_i;
      int          b;
      bit          miss;
      int          h0;
      int          fw;
      int          nb;
      int          n;
      logic [31:0] w;
      logic [31:0] e;
      t = a[11:5];
      hit_i = -1;
      while (!req_ready) @(negedge clk);
      for (int i = 0; i < 2; i++) if (m_val[i] && m_tag[i] == t) hit_i = i;
      miss = (hit_i < 0);
      if (miss) begin
         b = 1 - m_mru;
         m_val[b] = 1'b1; m_tag[b] = t; m_gen[b] = gen; m_mru = b;
         exp_line = t; exp_fidx = 0;
      end else begin
         b = hit_i; m_mru = hit_i;
      end
      h0 = hs_cnt;
      req_valid = 1'b1; req_addr = a; req_size = sz; req_burst = bu;
      @(negedge clk);
      req_valid = 1'b0;
      if (!miss) begin
         check(rsp_valid === 1'b1, "R2 hit beat one cycle after accept", 32'(rsp_valid), 32'd1);
      end else begin
         check(rsp_valid === 1'b0, "R3 no beat before fill", 32'(rsp_valid), 32'd0);
         n = 0;
         while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
         check(cyc == last_hs_cyc + 1, "R4 beat one cycle after last fill word",
               32'(cyc), 32'(last_hs_cyc + 1));
      end
      check(hs_cnt - h0 == (miss ? 8 : 0), "R3/R5 array word count (hit or miss)",
            32'(hs_cnt - h0), miss ? 32'd8 : 32'd0);
      fw = int'(a[4:2]);
      nb = bu ? 8 - fw : 1;
      for (int k = 0; k < nb; k++) begin
         w = mdl({t, 3'(fw + k)}, m_gen[b]);
         if (bu || sz >= 2)  e = w;
         else if (sz == 0)   e = (w >> (8 * a[1:0])) & 32'hFF;
         else                e = (w >> (16 * a[1])) & 32'hFFFF;
         check(rsp_valid === 1'b1, "R7 beat present", 32'(rsp_valid), 32'd1);
         check(rsp_data === e, bu ? "R7 burst word data" : "R6 lane select data", rsp_data, e);
         check(rsp_last === (k == nb - 1), "R8 last flag on final beat", 32'(rsp_last), 32'(k == nb - 1));
         @(negedge clk);
      end
      check(req_ready === 1'b1 && rsp_valid === 1'b0, "R10 ready after last beat",
            32'({req_ready, rsp_valid}), 32'b10);
   endtask

   task automatic do_inv();
      while (!req_ready) @(negedge clk);
      inv_all = 1'b1;
      @(negedge clk);
      inv_all = 1'b0;
      m_val[0] = 1'b0; m_val[1] = 1'b0;
      gen++;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; inv_all = 1'b0; req_valid = 1'b0; req_addr = '0;
      req_size = 2'd0; req_burst = 1'b0; arr_ready = 1'b0; arr_data = '0;
      m_val[0] = 1'b0; m_val[1] = 1'b0; m_tag[0] = '0; m_tag[1] = '0;
      m_gen[0] = 0; m_gen[1] = 0; m_mru = 1;
      repeat (3) @(negedge clk);
      check(req_ready === 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
      check(rsp_valid === 1'b0 && arr_req === 1'b0, "R1 outputs quiet in reset",
            32'({rsp_valid, arr_req}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1, R6: first read misses, then every byte, halfword and word offset
      for (int o = 0; o < 32; o++)    do_read(12'h060 + 12'(o), 2'd0, 1'b0);
      for (int o = 0; o < 32; o++)    do_read(12'h060 + 12'(o), 2'd1, 1'b0);
      for (int o = 0; o < 32; o += 4) do_read(12'h060 + 12'(o), 2'd2, 1'b0);

      // R7, R8: bursts from every word, size field ignored
      for (int s = 0; s < 3; s++)
         for (int wd = 0; wd < 8; wd++)
            do_read(12'h0A0 + 12'(wd * 4 + (wd % 4)), 2'(s), 1'b1);

      // R5: replacement order across lines
      do_read(12'h100, 2'd2, 1'b0);
      do_read(12'h120, 2'd2, 1'b0);
      do_read(12'h104, 2'd2, 1'b0);
      do_read(12'h140, 2'd2, 1'b0);
      do_read(12'h108, 2'd2, 1'b0);
      do_read(12'h124, 2'd2, 1'b1);
      do_read(12'h14C, 2'd1, 1'b0);
      for (int i = 0; i < 40; i++)
         do_read(12'((((i * 7) % 5) * 32) + ((i * 12) % 32)), 2'(i % 3), i % 4 == 0);

      // R9: global invalidate forces refetch with new contents
      do_read(12'h100, 2'd2, 1'b0);
      do_inv();
      do_read(12'h100, 2'd2, 1'b0);
      do_read(12'h11C, 2'd0, 1'b0);

      finish_run();
   end

endmodule